// File: doc/BRIEF.md
# Reference and Change Bit Updater

After an address translation has found a valid leaf entry and passed its permission check, this block performs the bookkeeping on that entry. It takes the 64-bit leaf entry, the physical address where the entry is stored, the kind of access and the permission vector the check produced. It then forms the updated entry. The reference bit is always set. The change bit is set only on a store.

If the updated entry equals the original, no memory traffic is generated. Otherwise one 64-bit write request carries the new entry back to the entry's address and is held until the memory side acknowledges it.

The block also returns a permission vector for the translation cache. For any access other than a store, write permission is removed from that vector. A later store to the same page therefore misses in the cache and comes back through this path, which is what sets the change bit.

Top module: `rc_bit_updater`

## Requirements
- R1: After reset the block is idle: `wr_req`, `done` and `busy` are low.
- R2: The updated entry (`entry_out`, and `wr_data` when written) always has bit 8 (reference) set.
- R3: Bit 7 (change) of the updated entry is set when `acc_type` is 1 (store). For `acc_type` 0 (load), 2 (fetch) and 3 (treated as a load), bit 7 keeps its original value.
- R4: Every entry bit other than 7 and 8 is passed through unchanged.
- R5: `perm_out` uses bit 0 for read, bit 1 for write and bit 2 for execute. It equals `perm_in` on a store. On any other access type it equals `perm_in` with bit 1 cleared.
- R6: A write request is raised only when the updated entry differs from the original. When the entries are equal, `done` is high in the cycle right after the cycle in which `start` was sampled, and `wr_req` stays low for the whole operation.
- R7: Once raised, `wr_req` stays high with `wr_addr` and `wr_data` stable until `wr_ack` is sampled high. `done` follows in the next cycle, and `wr_req` is low in that cycle.
- R8: `done` is a single-cycle pulse, after which the block is idle again.
- R9: `start` is ignored while the block is busy, and `wr_ack` is ignored while no request is pending.
- R10: `wr_addr` equals the `entry_addr` captured with `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an update; sampled only when idle |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch, 3 treated as load |
| entry_in | input | 64 | Leaf entry as read from memory |
| entry_addr | input | 56 | Physical address of the leaf entry |
| perm_in | input | 3 | Permissions granted: bit0 read, bit1 write, bit2 execute |
| wr_req | output | 1 | 64-bit memory write request, held until acknowledged |
| wr_addr | output | 56 | Write address |
| wr_data | output | 64 | Updated entry to store |
| wr_ack | input | 1 | Write acknowledge from memory |
| done | output | 1 | One-cycle completion pulse |
| entry_out | output | 64 | Updated entry |
| perm_out | output | 3 | Trimmed permission vector |
| busy | output | 1 | High from the cycle after start until done has ended |

## Verification
When no write is needed, `done`, `entry_out` and `perm_out` are due one cycle after the edge that samples `start`. When a write is needed, `wr_req` appears on that cycle instead and `done` comes one cycle after the edge that samples `wr_ack`. A behavioural model in the bench advances on each rising edge from the same sampled inputs. Every output is compared with that model at the following falling edge, so each result is checked exactly in the cycle it is due. Acknowledge delays of zero and several cycles, an acknowledge while idle, and a start while busy are all included.

// File: rtl/rc_bit_updater.sv
module rc_bit_updater #(
  parameter int ENTRY_W = 64,
  parameter int ADDR_W  = 56,
  parameter int REF_BIT = 8,
  parameter int CHG_BIT = 7,
  parameter int PERM_W  = 3,
  parameter int WR_PERM = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         acc_type,
  input  logic [ENTRY_W-1:0] entry_in,
  input  logic [ADDR_W-1:0]  entry_addr,
  input  logic [PERM_W-1:0]  perm_in,
  output logic               wr_req,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [ENTRY_W-1:0] wr_data,
  input  logic               wr_ack,
  output logic               done,
  output logic [ENTRY_W-1:0] entry_out,
  output logic [PERM_W-1:0]  perm_out,
  output logic               busy
);
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [ENTRY_W-1:0] REF_MASK = ENTRY_W'(1) << REF_BIT;
  localparam logic [ENTRY_W-1:0] CHG_MASK = ENTRY_W'(1) << CHG_BIT;
  localparam logic [PERM_W-1:0]  WR_MASK  = PERM_W'(1) << WR_PERM;

  typedef enum logic [1:0] {S_IDLE, S_WRITE, S_DONE} state_t;

  state_t state;
  logic [ENTRY_W-1:0] entry_q, next_entry;
  logic [ADDR_W-1:0]  addr_q;
  logic [PERM_W-1:0]  perm_q, next_perm;
  logic               is_store, accept;

  assign is_store   = (acc_type == ACC_STORE);
  assign next_entry = entry_in | REF_MASK | (is_store ? CHG_MASK : '0);
  assign next_perm  = is_store ? perm_in : (perm_in & ~WR_MASK);
  assign accept     = (state == S_IDLE) && start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      entry_q <= '0;
      addr_q  <= '0;
      perm_q  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          entry_q <= next_entry;
          addr_q  <= entry_addr;
          perm_q  <= next_perm;
          state   <= (next_entry != entry_in) ? S_WRITE : S_DONE;
        end
        S_WRITE: if (wr_ack) state <= S_DONE;
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign wr_req    = (state == S_WRITE);
  assign done      = (state == S_DONE);
  assign busy      = (state != S_IDLE);
  assign wr_addr   = addr_q;
  assign wr_data   = entry_q;
  assign entry_out = entry_q;
  assign perm_out  = perm_q;

  a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_data) && $stable(wr_addr)));
  a_r7_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_ack) |=> (done && !wr_req));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  a_r2_ref_set: assert property (@(posedge clk) disable iff (!rst_n)
    (done || wr_req) |-> entry_out[REF_BIT]);
  a_r6_req_excl_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_req && done));
endmodule

// File: tb/tb_rc_bit_updater.sv
module tb_rc_bit_updater;
  logic clk = 0, rst_n = 0, start = 0, wr_ack = 0;
  logic [1:0] acc_type = 0;
  logic [63:0] entry_in = 0;
  logic [55:0] entry_addr = 0;
  logic [2:0] perm_in = 0;
  logic wr_req, done, busy;
  logic [55:0] wr_addr;
  logic [63:0] wr_data, entry_out;
  logic [2:0] perm_out;
  int total = 0, bad = 0, cyc = 0;

  always #5 clk = ~clk;

  rc_bit_updater dut (
    .clk(clk), .rst_n(rst_n), .start(start), .acc_type(acc_type),
    .entry_in(entry_in), .entry_addr(entry_addr), .perm_in(perm_in),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .done(done), .entry_out(entry_out), .perm_out(perm_out), .busy(busy));

  // behavioural model: phase 0 idle, 1 writing, 2 done
  int m_ph = 0;
  logic [63:0] m_entry = 0;
  logic [63:0] m_orig = 0;
  logic [55:0] m_addr = 0;
  logic [2:0]  m_perm = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_ph = 0;
    else if (m_ph == 0) begin
      if (start) begin
        m_orig = entry_in;
        m_entry = entry_in;
        m_entry[8] = 1'b1;
        if (acc_type == 2'd1) m_entry[7] = 1'b1;
        m_addr = entry_addr;
        m_perm = perm_in;
        if (acc_type != 2'd1) m_perm[1] = 1'b0;
        m_ph = (m_entry != entry_in) ? 1 : 2;
      end
    end else if (m_ph == 1) begin
      if (wr_ack) m_ph = 2;
    end else m_ph = 0;
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R6 wr_req", 64'(wr_req), 64'(m_ph == 1));
      chk("R8 done", 64'(done), 64'(m_ph == 2));
      chk("R9 busy", 64'(busy), 64'(m_ph != 0));
      if (m_ph != 0) begin
        chk("R2 ref bit", 64'(entry_out[8]), 64'(1'b1));
        chk("R3 change bit", 64'(entry_out[7]), 64'(m_entry[7]));
        chk("R4 other bits", entry_out & ~64'h180, m_orig & ~64'h180);
        chk("R5 perm", 64'(perm_out), 64'(m_perm));
      end
      if (m_ph == 1) begin
        chk("R10 wr_addr", 64'(wr_addr), 64'(m_addr));
        chk("R7 wr_data", wr_data, m_entry);
      end
    end
    if (cyc > 20000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run(logic [1:0] a, logic [63:0] e, logic [55:0] ad,
                     logic [2:0] p, int ackdly, bit busy_start);
    int cnt = ackdly;
    @(negedge clk);
    start = 1; acc_type = a; entry_in = e; entry_addr = ad; perm_in = p;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 100; i++) begin
      if (done) break;
      if (busy_start) begin  // R9: start while busy, different entry
        start = 1; entry_in = ~e; acc_type = 2'd1; entry_addr = ~ad;
      end
      if (wr_req) begin
        if (cnt == 0) wr_ack = 1; else cnt--;
      end
      @(negedge clk);
      wr_ack = 0; start = 0;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 wr_req reset", 64'(wr_req), 0);
    chk("R1 done reset", 64'(done), 0);
    chk("R1 busy reset", 64'(busy), 0);
    rst_n = 1;
    // R9: ack while idle ignored
    @(negedge clk); wr_ack = 1; @(negedge clk); wr_ack = 0;
    run(2'd0, 64'hC000_0000_1234_5007, 56'h10_0000, 3'b111, 0, 0); // load, R clear
    run(2'd0, 64'hC000_0000_1234_5107, 56'h10_0008, 3'b011, 0, 0); // load, R set: no write
    run(2'd1, 64'hC000_0000_ABCD_E106, 56'h20_0000, 3'b011, 3, 0); // store, C clear
    run(2'd1, 64'hC000_0FFF_FFFF_F18F, 56'h20_0010, 3'b111, 0, 0); // store, R+C set
    run(2'd2, 64'hC000_0000_5555_5081, 56'h30_0000, 3'b110, 1, 0); // fetch
    run(2'd3, 64'hC000_0000_0000_0180, 56'h30_0008, 3'b010, 0, 0); // code 3: no write
    run(2'd0, 64'hC0FF_FFFF_FFFF_FE7F, 56'hFF_FFF8, 3'b111, 5, 1); // R9 busy start
    run(2'd1, 64'h0000_0000_0000_0000, 56'h00_0000, 3'b000, 2, 1);
    run(2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 56'h12_3450, 3'b101, 0, 0);
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule